// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block turns parallel audio samples into a self-clocking consumer or professional digital audio line stream. Samples arrive over a ready/valid handshake, one word per output lane per subframe. Subframes alternate between the even and the odd channel, and 384 of them make one block. Each subframe carries a sync preamble, a 24-bit sample, and four service bits: validity, user data, channel status, and parity. The block inserts the service bits itself. It then biphase-mark encodes the subframe onto the line.

The design is clocked at twice the bit rate, so one clock cycle is one half-cell on the line. A subframe lasts 64 cycles. Channel-status and user bits are read from two host-writable bit memories, each with one entry per subframe of the block. The validity bit comes from one of two level inputs, chosen by whether the subframe is even or odd.

Every lane runs from a single shared timing engine. The lanes therefore switch in the same cycles and carry the same service bits. Each lane carries its own audio. A sample is requested one subframe ahead. When no sample is waiting, the block sends silence and flags the underrun.

Top module: `bmc_audio_tx`

## Requirements
- R1: In slots 4 to 31, every bit cell starts with a line transition. A cell carrying 1 has a second transition at mid-cell, and a cell carrying 0 has none.
- R2: A subframe is 64 half-cells (32 slots). Slots 0-3 hold the preamble. Slots 4-27 hold audio bits 0 to 23, least significant first. Slot 28 is validity, slot 29 is user, slot 30 is channel status, and slot 31 is parity.
- R3: The preamble pattern depends on the subframe. Subframe 0 of the block uses 11101000. Other even subframes use 11100010. Odd subframes use 11100100. These patterns apply when the line level before the subframe is 0; when that level is 1, the pattern is inverted.
- R4: The parity slot makes slots 4 to 31 contain an even number of ones.
- R5: Subframe n carries entry n of the channel-status memory and entry n of the user memory. A host write with `cfg_we` high stores `cfg_bit` at `cfg_addr`. `cfg_sel`=0 selects the channel-status memory and `cfg_sel`=1 selects the user memory. A write made at least a full subframe before the subframe that uses the entry takes effect.
- R6: The validity slot carries `val_even` in even subframes and `val_odd` in odd subframes.
- R7: `sf_index` gives the subframe currently on the line. It steps by one at each subframe start and wraps from 383 to 0.
- R8: `s_ready` is high while the one-entry holding register is empty. After a transfer, `s_ready` is low on the next cycle. Accepted samples are sent in order, each in the next subframe that starts after it was taken.
- R9: Only bits 23..0 of each lane's 32-bit input word are sent. The upper bits have no effect on the line.
- R10: If no sample is waiting when a subframe is loaded, that subframe carries zero audio. `underrun` is high for one cycle, in the last half-cell of the preceding subframe.
- R11: All lanes are cycle-aligned and carry identical preambles and service bits. Each lane carries its own audio slice of `s_data`.
- R12: While `rst` is high, `tx_out` and `underrun` are 0, `sf_index` is 383, and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock (twice the bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | LANES*IN_W | One sample word per lane, lane 0 in the low bits |
| s_valid | input | 1 | Sample words are valid |
| s_ready | output | 1 | Holding register can take a sample set |
| val_even | input | 1 | Validity bit for even subframes |
| val_odd | input | 1 | Validity bit for odd subframes |
| cfg_we | input | 1 | Write strobe for the service-bit memories |
| cfg_sel | input | 1 | 0 = channel-status memory, 1 = user memory |
| cfg_addr | input | $clog2(BLOCK_LEN) | Subframe entry to write |
| cfg_bit | input | 1 | Bit value to write |
| tx_out | output | LANES | Encoded line, one bit per lane |
| underrun | output | 1 | One-cycle pulse when silence is substituted |
| sf_index | output | $clog2(BLOCK_LEN) | Number of the subframe on the line |

## Verification
Two things can fall on the same clock edge: a sample handshake completing, and the subframe boundary that drains the holding register. The bench drops `s_valid` for several subframes in a row, and for a single subframe, at two points in the run. This empties the holding register. The refill then lands next to a boundary, and some subframes are loaded with nothing waiting. The bench keeps its own queue of accepted sample sets and its own record of underrun pulses. From these it predicts, for every decoded subframe, whether that subframe carries the next queued sample or silence, and it checks that no sample is lost or duplicated.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  localparam int SLOTS      = 32;              // bit cells per subframe
  localparam int HALVES     = 2 * SLOTS;       // half-cells per subframe
  localparam int HC_W       = $clog2(HALVES);
  localparam int AUD_W      = 24;              // audio bits per subframe
  localparam int PRE_HALVES = 8;               // preamble length in half-cells

  typedef enum logic [1:0] {
    SYNC_BLOCK = 2'd0,
    SYNC_EVEN  = 2'd1,
    SYNC_ODD   = 2'd2
  } sync_kind_t;

  // Preamble half-cell patterns for a line resting at 0, first half-cell in bit 7.
  function automatic logic [7:0] sync_pattern(sync_kind_t kind);
    case (kind)
      SYNC_BLOCK: return 8'b1110_1000;
      SYNC_EVEN:  return 8'b1110_0010;
      default:    return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/bmc_bitram.sv
module bmc_bitram #(
  parameter int DEPTH = 384,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic mem [DEPTH];

  // One write port, one registered read port: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
    rbit <= mem[raddr];
  end
endmodule

// File: rtl/bmc_timing.sv
module bmc_timing
  import bmc_tx_pkg::*;
#(
  parameter int BLOCK_LEN = 384,
  localparam int AW = $clog2(BLOCK_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [HC_W-1:0] hc,       // half-cell the next edge produces
  output logic            bnd,      // next edge closes the subframe
  output logic [AW-1:0]   sf_nx,    // subframe that follows the current one
  output logic [7:0]      pre_pat,  // preamble of the current subframe
  output logic [AW-1:0]   sf_line   // subframe whose half-cells are on the line
);
  localparam logic [AW-1:0] LAST = AW'(BLOCK_LEN - 1);

  logic [AW-1:0] sf_q;
  sync_kind_t    kind;

  assign bnd   = (hc == {HC_W{1'b1}});
  assign sf_nx = (sf_q == LAST) ? '0 : sf_q + AW'(1);

  always_comb begin
    if (sf_q == '0)   kind = SYNC_BLOCK;
    else if (sf_q[0]) kind = SYNC_ODD;
    else              kind = SYNC_EVEN;
  end
  assign pre_pat = sync_pattern(kind);

  // Reset parks the engine on the last half-cell of the last subframe,
  // so the first edge after reset loads subframe 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      hc      <= {HC_W{1'b1}};
      sf_q    <= LAST;
      sf_line <= LAST;
    end else begin
      hc <= hc + HC_W'(1);
      if (bnd)       sf_q    <= sf_nx;
      if (hc == '0)  sf_line <= sf_q;
    end
  end
endmodule

// File: rtl/bmc_lane.sv
module bmc_lane
  import bmc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [HC_W-1:0]  hc,
  input  logic             bnd,
  input  logic [7:0]       pre_pat,
  input  logic [AUD_W-1:0] aud,
  input  logic             v_bit,
  input  logic             u_bit,
  input  logic             c_bit,
  output logic             line
);
  logic [SLOTS-1:0] word_q;    // slot-indexed subframe being sent
  logic             base_q;    // line level before the preamble
  logic [4:0]       slot;
  logic             cell_bit;
  logic             par;

  assign slot     = hc[HC_W-1:1];
  assign cell_bit = word_q[slot];
  assign par      = ^{c_bit, u_bit, v_bit, aud};

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      base_q <= 1'b0;
      line   <= 1'b0;
    end else begin
      if (bnd) word_q <= {par, c_bit, u_bit, v_bit, aud, 4'b0000};
      if (hc < HC_W'(PRE_HALVES)) begin
        if (hc == '0) begin
          line   <= pre_pat[7] ^ line;
          base_q <= line;
        end else begin
          line <= pre_pat[~hc[2:0]] ^ base_q;
        end
      end else if (!hc[0]) begin
        line <= ~line;               // every cell opens with a transition
      end else begin
        line <= line ^ cell_bit;     // a one adds a mid-cell transition
      end
    end
  end
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmc_tx_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int BLOCK_LEN = 384,
  parameter int IN_W      = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANES*IN_W-1:0]        s_data,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic                         val_even,
  input  logic                         val_odd,
  input  logic                         cfg_we,
  input  logic                         cfg_sel,
  input  logic [$clog2(BLOCK_LEN)-1:0] cfg_addr,
  input  logic                         cfg_bit,
  output logic [LANES-1:0]             tx_out,
  output logic                         underrun,
  output logic [$clog2(BLOCK_LEN)-1:0] sf_index
);
  localparam int AW = $clog2(BLOCK_LEN);

  logic [HC_W-1:0]        hc_w;
  logic                   bnd_w;
  logic [AW-1:0]          sf_nx_w;
  logic [7:0]             pre_w;
  logic                   cs_rd, us_rd, v_cur;
  logic [LANES*AUD_W-1:0] hold_q;
  logic                   full_q, under_q;
  logic                   accept;

  bmc_timing #(.BLOCK_LEN(BLOCK_LEN)) u_timing (
    .clk(clk), .rst(rst), .hc(hc_w), .bnd(bnd_w), .sf_nx(sf_nx_w),
    .pre_pat(pre_w), .sf_line(sf_index)
  );

  bmc_bitram #(.DEPTH(BLOCK_LEN)) u_cs_ram (
    .clk(clk), .we(cfg_we & ~cfg_sel), .waddr(cfg_addr), .wbit(cfg_bit),
    .raddr(sf_nx_w), .rbit(cs_rd)
  );

  bmc_bitram #(.DEPTH(BLOCK_LEN)) u_us_ram (
    .clk(clk), .we(cfg_we & cfg_sel), .waddr(cfg_addr), .wbit(cfg_bit),
    .raddr(sf_nx_w), .rbit(us_rd)
  );

  // One-entry holding register: filled by the handshake, drained at the boundary.
  assign accept = s_valid & ~full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      under_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      under_q <= bnd_w & ~full_q;
      if (accept)     full_q <= 1'b1;
      else if (bnd_w) full_q <= 1'b0;
      if (accept) begin
        for (int i = 0; i < LANES; i++)
          hold_q[i*AUD_W +: AUD_W] <= s_data[i*IN_W +: AUD_W];
      end
    end
  end

  assign s_ready  = ~full_q;
  assign underrun = under_q;
  assign v_cur    = sf_nx_w[0] ? val_odd : val_even;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AUD_W-1:0] aud_g;
    assign aud_g = full_q ? hold_q[g*AUD_W +: AUD_W] : '0;

    if (IN_W > AUD_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^s_data[g*IN_W+AUD_W +: IN_W-AUD_W];
    end

    bmc_lane u_lane (
      .clk(clk), .rst(rst), .hc(hc_w), .bnd(bnd_w), .pre_pat(pre_w),
      .aud(aud_g), .v_bit(v_cur), .u_bit(us_rd), .c_bit(cs_rd),
      .line(tx_out[g])
    );
  end
endmodule

// File: rtl/bmc_tx_checks.sv
module bmc_tx_checks
  import bmc_tx_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int BLOCK_LEN = 384,
  localparam int AW = $clog2(BLOCK_LEN)
) (
  input logic            clk,
  input logic            rst,
  input logic [LANES-1:0] tx_out,
  input logic            s_valid,
  input logic            s_ready,
  input logic            underrun,
  input logic [AW-1:0]   sf_index,
  input logic [HC_W-1:0] hc
);
  localparam logic [AW-1:0] LAST = AW'(BLOCK_LEN - 1);

  for (genvar g = 0; g < LANES; g++) begin : g_edge
    // R1: a data cell always opens with a level change
    p_cell_edge_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(hc) >= HC_W'(PRE_HALVES) && !$past(hc[0])) |-> (tx_out[g] != $past(tx_out[g])));
  end

  // R11: lanes agree on every preamble half-cell
  p_lane_sync_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(hc) < HC_W'(PRE_HALVES)) |-> (tx_out == {LANES{tx_out[0]}}));

  // R8: holding register closes after a transfer
  p_ready_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R7: the subframe number steps by one and wraps
  p_sf_step_r7: assert property (@(posedge clk) disable iff (rst)
    (sf_index != $past(sf_index)) |->
      (sf_index == (($past(sf_index) == LAST) ? '0 : $past(sf_index) + AW'(1))));

  // R7: the subframe number moves only with the first half-cell of a subframe
  p_sf_align_r7: assert property (@(posedge clk) disable iff (rst)
    (sf_index != $past(sf_index)) |-> ($past(hc) == '0));

  // R10: underrun only closes a subframe loaded with nothing waiting
  p_underrun_r10: assert property (@(posedge clk) disable iff (rst)
    underrun |-> ($past(hc) == {HC_W{1'b1}} && $past(s_ready)));
endmodule

bind bmc_audio_tx bmc_tx_checks #(.LANES(LANES), .BLOCK_LEN(BLOCK_LEN)) u_checks (
  .clk(clk), .rst(rst), .tx_out(tx_out), .s_valid(s_valid), .s_ready(s_ready),
  .underrun(underrun), .sf_index(sf_index), .hc(hc_w)
);

// File: tb/bmc_audio_tx_test.sv
module bmc_audio_tx_test;
  localparam int LANES = 2;
  localparam int BLK   = 384;
  localparam int IN_W  = 32;
  localparam int AW    = $clog2(BLK);
  localparam int RUN_SUBS = 800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES*IN_W-1:0] s_data;
  logic s_valid = 1'b0;
  logic s_ready;
  logic val_even = 1'b1, val_odd = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_bit = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [LANES-1:0] tx_out;
  logic underrun;
  logic [AW-1:0] sf_index;

  always #4 clk = ~clk;

  bmc_audio_tx #(.LANES(LANES), .BLOCK_LEN(BLK), .IN_W(IN_W)) uut (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .val_even(val_even), .val_odd(val_odd), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_bit(cfg_bit), .tx_out(tx_out),
    .underrun(underrun), .sf_index(sf_index)
  );

  int n_chk = 0, n_bad = 0;
  int subs_done = 0;
  bit cs_ref [BLK];
  bit us_ref [BLK];
  logic [LANES*IN_W-1:0] fifo [0:2047];
  int wr_p = 0, rd_p = 0;
  logic [LANES-1:0] hbuf [0:127];
  int cnt = 0;
  int cur_sf = BLK - 1;
  bit active = 0, uflag = 0, acc_flag = 0, acc_prev = 0;
  logic [LANES-1:0] last_tx = '0, prev_start = '0;
  bit exp_zero, exp_v, exp_u, exp_c;
  logic [LANES*IN_W-1:0] exp_word;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (sf %0d)", req, act, exp, cur_sf);
    end
  endtask

  function automatic bit cs_fn(int a);
    return ((a % 3) == 0) ^ ((a % 7) == 1);
  endfunction
  function automatic bit us_fn(int a);
    return ((a % 5) == 2) || (a == BLK - 1);
  endfunction
  function automatic logic [7:0] pat_of(int sf);
    if (sf == 0) return 8'hE8;
    return (sf % 2 == 1) ? 8'hE4 : 8'hE2;
  endfunction

  function automatic logic [LANES*IN_W-1:0] gen(int n);
    logic [23:0] a0, a1;
    case (n)
      1: begin a0 = 24'hFFFFFF; a1 = 24'h000000; end
      2: begin a0 = 24'h000000; a1 = 24'hFFFFFF; end
      3: begin a0 = 24'h000001; a1 = 24'h800000; end
      4: begin a0 = 24'h800000; a1 = 24'h000001; end
      default: begin
        a0 = 24'(n * 40503 + 24'h123457);
        a1 = 24'(n * 9973) ^ 24'h5A5A5A;
      end
    endcase
    return {8'(n * 37 + 1), a1, 8'(~n), a0};  // upper bytes are junk (R9)
  endfunction

  // Decode one collected subframe on every lane and compare.
  task automatic process_sf();
    logic [7:0] pat, got0;
    pat = pat_of(cur_sf);
    check(cnt == 64, "R2 half-cells per subframe", 32'(cnt), 32'd64);
    for (int j = 0; j < 8; j++) got0[7-j] = hbuf[j][0];
    for (int l = 0; l < LANES; l++) begin
      logic [7:0] got;
      logic [31:0] bits;
      bit edge_ok;
      logic [23:0] exp_aud;
      for (int j = 0; j < 8; j++) got[7-j] = hbuf[j][l];
      check(got == (pat ^ {8{prev_start[l]}}), "R3 preamble", 32'(got), 32'(pat ^ {8{prev_start[l]}}));
      check(got == got0, "R11 lanes share preamble", 32'(got), 32'(got0));
      edge_ok = 1;
      bits = '0;
      for (int k = 4; k < 32; k++) begin
        if (hbuf[2*k][l] == hbuf[2*k-1][l]) edge_ok = 0;
        bits[k] = hbuf[2*k][l] ^ hbuf[2*k+1][l];
      end
      check(edge_ok, "R1 cell-start transitions", 32'(edge_ok), 32'd1);
      exp_aud = exp_word[l*IN_W +: 24];
      if (exp_zero)
        check(bits[27:4] == 24'd0, "R10 underrun sends zero audio", 32'(bits[27:4]), 32'd0);
      else
        check(bits[27:4] == exp_aud, "R2 R9 R11 lane audio LSB first", 32'(bits[27:4]), 32'(exp_aud));
      check(bits[28] == exp_v, "R6 validity slot", 32'(bits[28]), 32'(exp_v));
      check(bits[29] == exp_u, "R5 user slot", 32'(bits[29]), 32'(exp_u));
      check(bits[30] == exp_c, "R5 channel-status slot", 32'(bits[30]), 32'(exp_c));
      check((^bits[31:4]) == 1'b0, "R4 even parity", 32'(^bits[31:4]), 32'd0);
    end
  endtask

  // Monitor: samples at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (int'(sf_index) != cur_sf) begin
        if (active) begin
          process_sf();
          check(int'(sf_index) == ((cur_sf + 1) % BLK), "R7 subframe sequence",
                32'(sf_index), 32'((cur_sf + 1) % BLK));
        end
        active     = 1;
        prev_start = last_tx;
        cur_sf     = int'(sf_index);
        exp_zero   = uflag;
        uflag      = 0;
        if (!exp_zero && rd_p < wr_p) begin exp_word = fifo[rd_p % 2048]; rd_p++; end
        else exp_word = '0;
        exp_v = (cur_sf % 2 == 1) ? val_odd : val_even;
        exp_u = us_ref[cur_sf];
        exp_c = cs_ref[cur_sf];
        cnt = 0;
        subs_done++;
      end
      if (cnt < 128) hbuf[cnt] = tx_out;
      cnt++;
      if (underrun) uflag = 1;
      if (acc_prev) check(!s_ready, "R8 ready drops after transfer", 32'(s_ready), 32'd0);
      acc_prev = s_valid && s_ready;
      if (acc_prev) begin fifo[wr_p % 2048] = s_data; wr_p++; acc_flag = 1; end
      last_tx = tx_out;
    end
  end

  // Reset, memory load and run-time configuration.
  initial begin
    repeat (3) @(negedge clk);
    check(tx_out == '0, "R12 reset line low", 32'(tx_out), 32'd0);
    check(underrun == 1'b0, "R12 reset no underrun", 32'(underrun), 32'd0);
    check(int'(sf_index) == BLK - 1, "R12 reset subframe number", 32'(sf_index), 32'(BLK - 1));
    check(s_ready == 1'b1, "R12 reset ready", 32'(s_ready), 32'd1);
    for (int a = 0; a < BLK; a++) begin
      cfg_we = 1; cfg_sel = 0; cfg_addr = AW'(a); cfg_bit = cs_fn(a); cs_ref[a] = cs_fn(a);
      @(negedge clk);
    end
    for (int a = 0; a < BLK; a++) begin
      cfg_we = 1; cfg_sel = 1; cfg_addr = AW'(a); cfg_bit = us_fn(a); us_ref[a] = us_fn(a);
      @(negedge clk);
    end
    cfg_we = 0;
    repeat (4) @(negedge clk);
    check(tx_out == '0, "R12 line low while held in reset", 32'(tx_out), 32'd0);
    rst = 0;
    wait (subs_done >= 10);
    repeat (20) @(posedge clk);
    #1;
    cfg_we = 1; cfg_sel = 0; cfg_addr = AW'(100); cfg_bit = ~cs_ref[100]; cs_ref[100] = ~cs_ref[100];
    @(posedge clk); #1;
    cfg_sel = 1; cfg_addr = AW'(BLK - 1); cfg_bit = 1'b0; us_ref[BLK-1] = 1'b0;
    @(posedge clk); #1;
    cfg_we = 0;
    wait (subs_done >= 390);
    repeat (20) @(posedge clk);
    #1;
    val_even = 1'b0; val_odd = 1'b1;
  end

  // Sample feeder with gaps that force underruns (R8, R10).
  initial begin
    int n;
    n = 1;
    s_data = gen(1);
    wait (!rst);
    forever begin
      @(posedge clk);
      #1;
      if (acc_flag) begin acc_flag = 0; n++; s_data = gen(n); end
      s_valid = !((subs_done >= 300 && subs_done < 304) || subs_done == 520);
    end
  end

  initial begin
    wait (subs_done >= RUN_SUBS);
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired at subframe count %0d", subs_done);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule